// File: doc/BRIEF.md
# Strided Two-Way Block DMA Engine

This block copies 64-bit words between a two-bank local scratch memory and a larger byte-addressed external memory. Software programs a local address, an external address and a length word through a small register port. Writing the length word through one of two selectors starts the transfer, and the selector sets its direction. A transfer is a rectangle of rows that all have the same length. Between rows the external address can jump over a gap, so a strided region of external memory packs into a contiguous run of local memory, or unpacks from one.

The local memory and the external memory both sit outside the block. Local memory is reached through a word port with a combinational read and a write enable. External memory is reached through a valid/ready request channel that carries one word per accepted cycle. Read data comes back in the same cycle the request is accepted. Addresses are held aligned to 8 bytes and wrap inside their address spaces. When a transfer ends, the length word holds a fixed finished pattern.

Top module: `strided_dma`

## Requirements
- R1: Writing selector 0 keeps only bits 12:3 of the data as the local address, and reading selector 0 returns that masked value. Bit 12 picks the bank and bits 11:3 give the word offset inside the 4 KiB bank.
- R2: Writing selector 1 keeps only bits 23:3 of the data as the external address, and reading selector 1 returns that masked value.
- R3: The length word holds the row field in bits 11:0. A row carries that field plus one bytes, rounded up to a whole number of 8-byte words, and one word moves per accepted request.
- R4: The length word holds the row count field in bits 19:12, and a transfer moves that field plus one rows.
- R5: Inside a row, the external address rises by 8 for each word, modulo 2^24. After every row except the last, the next row starts at (start of the row + row bytes + skip) modulo 2^24, with bits 2:0 then cleared. The skip field is bits 31:20 of the length word.
- R6: The local word offset rises by one word per word moved and wraps inside its bank. The bank stays fixed for the whole transfer.
- R7: Writing selector 2 while idle starts an inbound transfer: the engine reads external memory and writes each word into local memory. Writing selector 3 while idle starts an outbound transfer: the engine reads local memory and writes external memory. Selectors 2 and 3 read back the same stored length word.
- R8: When a transfer ends, bits 19:0 of the length word read 0x00FF8 and the skip field in bits 31:20 is kept.
- R9: busy is high from the cycle after the starting write until the last word is accepted. A length write made while busy is high has no effect, and that includes a write in the same cycle as the last accepted word.
- R10: While a request is waiting for ready, its address and its local word index stay unchanged.
- R11: After reset all registers read zero, and busy and the request valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector (0 local, 1 external, 2 length/inbound, 3 length/outbound) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| busy | output | 1 | Transfer in progress |
| ext_valid | output | 1 | External request valid |
| ext_ready | input | 1 | External request accepted |
| ext_we | output | 1 | External request is a write |
| ext_addr | output | 24 | External byte address, 8-byte aligned |
| ext_wdata | output | 64 | External write data |
| ext_rdata | input | 64 | External read data, valid in the accepting cycle |
| lm_we | output | 1 | Local memory write enable |
| lm_bank | output | 1 | Local memory bank |
| lm_idx | output | 9 | Local word index within the bank |
| lm_wdata | output | 64 | Local memory write data |
| lm_rdata | input | 64 | Local memory read data for lm_bank/lm_idx |

## Verification
Two things can fall on the same clock edge: the acceptance of the final word, which loads the finished pattern into the length word, and a software write to a length selector. The bench holds ready low on a one-word transfer. In the cycle it raises ready, it also issues a length write carrying a different skip. The result is correct only if the length word afterwards shows the finished pattern with the original skip, busy stays low, and no further request appears.

// File: rtl/sdma_pkg.sv
`timescale 1ns/1ps
package sdma_pkg;
  localparam int unsigned WORD_SH = 3;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
  typedef enum logic {DIR_IN, DIR_OUT} xfer_dir_e;

  // words per row from the row field with its low three bits dropped
  function automatic logic [31:0] beats_from_field(input logic [31:0] wfield);
    return wfield + 32'd1;
  endfunction

  // byte mask for an aligned address inside a 2^aw space
  function automatic logic [31:0] span_mask(input int unsigned aw);
    return ((32'h1 << aw) - 32'h1) & ~32'h7;
  endfunction

  // add, wrap into the space and realign to a word
  function automatic logic [31:0] wrap_add(input logic [31:0] base,
                                           input logic [31:0] inc,
                                           input int unsigned aw);
    return (base + inc) & span_mask(aw);
  endfunction
endpackage

// File: rtl/sdma_regs.sv
`timescale 1ns/1ps
module sdma_regs import sdma_pkg::*; #(
  parameter int unsigned EXT_AW  = 24,
  parameter int unsigned BANK_AW = 12,
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned CNT_W   = 8,
  localparam int unsigned LO_W   = LEN_W + CNT_W,
  localparam int unsigned SKIP_W = 32 - LO_W,
  localparam int unsigned LOCW_W = BANK_AW - WORD_SH + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [1:0]             reg_sel,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   busy,
  input  logic                   xfer_done,
  output logic                   start_in,
  output logic                   start_out,
  output logic [LOCW_W-1:0]      loc_word,
  output logic [EXT_AW-1:0]      ext_base,
  output logic [LEN_W-4:0]       row_wfield,
  output logic [CNT_W-1:0]       row_cnt,
  output logic [SKIP_W-1:0]      row_skip
);
  localparam logic [LO_W-1:0] FIN_LO = LO_W'((32'h1 << LEN_W) - 32'h8);

  logic [31:0] len_q;
  logic        len_wr;

  assign len_wr    = reg_wr && reg_sel[1] && !busy;
  assign start_in  = len_wr && !reg_sel[0];
  assign start_out = len_wr &&  reg_sel[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_word <= '0;
      ext_base <= '0;
      len_q    <= '0;
    end else begin
      if (reg_wr && reg_sel == 2'd0) loc_word <= reg_wdata[BANK_AW:WORD_SH];
      if (reg_wr && reg_sel == 2'd1) ext_base <= {reg_wdata[EXT_AW-1:WORD_SH], 3'b000};
      if (len_wr)         len_q <= reg_wdata;
      else if (xfer_done) len_q <= {len_q[31:LO_W], FIN_LO};
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = 32'({loc_word, 3'b000});
      2'd1:    reg_rdata = 32'(ext_base);
      default: reg_rdata = len_q;
    endcase
  end

  assign row_wfield = len_q[LEN_W-1:WORD_SH];
  assign row_cnt    = len_q[LO_W-1:LEN_W];
  assign row_skip   = len_q[31:LO_W];

  // R8
  fin_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (len_q[LO_W-1:0] == FIN_LO) && $stable(len_q[31:LO_W]));
  // R9
  busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_sel[1] && !xfer_done |=> $stable(len_q));
  // R9
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_in || start_out) |=> busy);
endmodule

// File: rtl/sdma_seq.sv
`timescale 1ns/1ps
module sdma_seq import sdma_pkg::*; #(
  parameter int unsigned EXT_AW  = 24,
  parameter int unsigned BANK_AW = 12,
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DW      = 64,
  localparam int unsigned SKIP_W = 32 - LEN_W - CNT_W,
  localparam int unsigned IDX_W  = BANK_AW - WORD_SH,
  localparam int unsigned BEAT_W = LEN_W - WORD_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_in,
  input  logic               start_out,
  input  logic [IDX_W:0]     loc_word,
  input  logic [EXT_AW-1:0]  ext_base,
  input  logic [BEAT_W-1:0]  row_wfield,
  input  logic [CNT_W-1:0]   row_cnt,
  input  logic [SKIP_W-1:0]  row_skip,
  output logic               busy,
  output logic               xfer_done,
  output logic               ext_valid,
  input  logic               ext_ready,
  output logic               ext_we,
  output logic [EXT_AW-1:0]  ext_addr,
  output logic [DW-1:0]      ext_wdata,
  input  logic [DW-1:0]      ext_rdata,
  output logic               lm_we,
  output logic               lm_bank,
  output logic [IDX_W-1:0]   lm_idx,
  output logic [DW-1:0]      lm_wdata,
  input  logic [DW-1:0]      lm_rdata
);
  seq_state_e            state_q;
  xfer_dir_e             dir_q;
  logic [EXT_AW-1:0]     ext_cur;
  logic [IDX_W-1:0]      idx_q;
  logic                  bank_q;
  logic [BEAT_W-1:0]     beat_q;
  logic [CNT_W-1:0]      row_q;

  logic beat_fire, last_beat, last_row, launch;

  assign launch    = start_in || start_out;
  assign beat_fire = (state_q == ST_RUN) && ext_ready;
  assign last_beat = (32'(beat_q) + 32'd1) == beats_from_field(32'(row_wfield));
  assign last_row  = (row_q == row_cnt);
  assign xfer_done = beat_fire && last_beat && last_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_IN;
      ext_cur <= '0;
      idx_q   <= '0;
      bank_q  <= 1'b0;
      beat_q  <= '0;
      row_q   <= '0;
    end else if (launch) begin
      state_q <= ST_RUN;
      dir_q   <= start_out ? DIR_OUT : DIR_IN;
      ext_cur <= ext_base;
      idx_q   <= loc_word[IDX_W-1:0];
      bank_q  <= loc_word[IDX_W];
      beat_q  <= '0;
      row_q   <= '0;
    end else if (beat_fire) begin
      idx_q <= idx_q + 1'b1;
      if (last_beat) begin
        beat_q  <= '0;
        row_q   <= row_q + 1'b1;
        ext_cur <= EXT_AW'(wrap_add(32'(ext_cur), 32'd8 + 32'(row_skip), EXT_AW));
        if (last_row) state_q <= ST_IDLE;
      end else begin
        beat_q  <= beat_q + 1'b1;
        ext_cur <= EXT_AW'(wrap_add(32'(ext_cur), 32'd8, EXT_AW));
      end
    end
  end

  assign busy      = (state_q == ST_RUN);
  assign ext_valid = busy;
  assign ext_we    = busy && (dir_q == DIR_OUT);
  assign ext_addr  = ext_cur;
  assign ext_wdata = lm_rdata;
  assign lm_we     = beat_fire && (dir_q == DIR_IN);
  assign lm_bank   = bank_q;
  assign lm_idx    = idx_q;
  assign lm_wdata  = ext_rdata;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && !ext_ready |=> ext_valid && $stable(ext_addr) && $stable(lm_idx));
  // R5
  ext_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> ext_addr[2:0] == 3'b000);
  // R6
  bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && !xfer_done |=> $stable(lm_bank));
  // R7
  lm_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_we |-> ext_valid && ext_ready && !ext_we);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ext_valid && !lm_we);
endmodule

// File: rtl/strided_dma.sv
`timescale 1ns/1ps
module strided_dma import sdma_pkg::*; #(
  parameter int unsigned EXT_AW  = 24,
  parameter int unsigned BANK_AW = 12,
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DW      = 64,
  localparam int unsigned SKIP_W = 32 - LEN_W - CNT_W,
  localparam int unsigned IDX_W  = BANK_AW - WORD_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               busy,
  output logic               ext_valid,
  input  logic               ext_ready,
  output logic               ext_we,
  output logic [EXT_AW-1:0]  ext_addr,
  output logic [DW-1:0]      ext_wdata,
  input  logic [DW-1:0]      ext_rdata,
  output logic               lm_we,
  output logic               lm_bank,
  output logic [IDX_W-1:0]   lm_idx,
  output logic [DW-1:0]      lm_wdata,
  input  logic [DW-1:0]      lm_rdata
);
  logic                     start_in, start_out, xfer_done;
  logic [IDX_W:0]           loc_word;
  logic [EXT_AW-1:0]        ext_base;
  logic [LEN_W-4:0]         row_wfield;
  logic [CNT_W-1:0]         row_cnt;
  logic [SKIP_W-1:0]        row_skip;

  sdma_regs #(.EXT_AW(EXT_AW), .BANK_AW(BANK_AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .xfer_done(xfer_done), .start_in(start_in), .start_out(start_out),
    .loc_word(loc_word), .ext_base(ext_base), .row_wfield(row_wfield),
    .row_cnt(row_cnt), .row_skip(row_skip)
  );

  sdma_seq #(.EXT_AW(EXT_AW), .BANK_AW(BANK_AW), .LEN_W(LEN_W), .CNT_W(CNT_W), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .start_out(start_out),
    .loc_word(loc_word), .ext_base(ext_base), .row_wfield(row_wfield),
    .row_cnt(row_cnt), .row_skip(row_skip), .busy(busy), .xfer_done(xfer_done),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .lm_we(lm_we), .lm_bank(lm_bank), .lm_idx(lm_idx), .lm_wdata(lm_wdata),
    .lm_rdata(lm_rdata)
  );
endmodule

// File: tb/strided_dma_tb.sv
`timescale 1ns/1ps
module strided_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        busy, ext_valid, ext_we, lm_we, lm_bank;
  logic        ext_ready;
  logic [23:0] ext_addr;
  logic [63:0] ext_wdata, ext_rdata, lm_wdata, lm_rdata;
  logic [8:0]  lm_idx;

  logic [63:0] lmem [0:1023];

  int checks = 0, fails = 0;
  bit finished = 0;
  int rdy_mode = 0;
  bit rdy_force = 0;
  int fire_cnt = 0, mism = 0;
  int mm_got = 0, mm_exp = 0;
  bit exp_out = 0;
  int exp_ext[$];
  int exp_loc[$];

  always #2.5 clk = ~clk;

  function automatic logic [63:0] fdat(input logic [23:0] a);
    return {8'hA5, a, ~a, 8'h3C};
  endfunction

  function automatic logic [63:0] gdat(input int i);
    return {32'hC0DE0000 | 32'(i), 32'(i * 7 + 1)};
  endfunction

  assign ext_rdata = fdat(ext_addr);
  assign lm_rdata  = lmem[{lm_bank, lm_idx}];

  strided_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .lm_we(lm_we), .lm_bank(lm_bank), .lm_idx(lm_idx), .lm_wdata(lm_wdata),
    .lm_rdata(lm_rdata)
  );

  task automatic chk(input bit ok, input string req, input longint got, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, expv);
    end
  endtask

  // ready driver and beat monitor
  initial begin
    int cyc;
    cyc = 0;
    ext_ready = 1'b0;
    forever begin
      @(negedge clk);
      #0.5;
      cyc++;
      case (rdy_mode)
        0: ext_ready = 1'b1;
        1: ext_ready = cyc[0];
        2: ext_ready = rdy_force;
        default: ext_ready = (cyc % 3) != 0;
      endcase
      #0.5;
      if (ext_valid && ext_ready) begin
        fire_cnt++;
        if (exp_ext.size() == 0) begin
          if (mism == 0) begin mm_got = int'(ext_addr); mm_exp = -1; end
          mism++;
        end else begin
          int ea, el;
          ea = exp_ext.pop_front();
          el = exp_loc.pop_front();
          if (int'(ext_addr) != ea || int'({lm_bank, lm_idx}) != el) begin
            if (mism == 0) begin mm_got = int'({ext_addr, 1'b0, lm_bank, lm_idx}); mm_exp = (ea << 11) | el; end
            mism++;
          end
          if (!exp_out) begin
            if (!lm_we || ext_we || lm_wdata != fdat(24'(ea))) mism++;
            lmem[{lm_bank, lm_idx}] = lm_wdata;
          end else begin
            if (!ext_we || lm_we || ext_wdata != lmem[el]) mism++;
          end
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    do begin
      @(negedge clk); #2;
      n++;
    end while (busy && n < 5000);
  endtask

  // expected word sequence, computed from R3..R6
  task automatic plan(input logic [31:0] lv, input logic [31:0] ev, input logic [31:0] lenv,
                      output int nbeats);
    int bank, off, ext, len, cnt, skip, rb;
    bank = (lv >> 12) & 1;
    off  = lv & 32'hFF8;
    ext  = ev & 32'hFFFFF8;
    len  = lenv & 32'hFFF;
    cnt  = (lenv >> 12) & 32'hFF;
    skip = (lenv >> 20) & 32'hFFF;
    rb   = ((len + 1 + 7) / 8) * 8;
    exp_ext.delete();
    exp_loc.delete();
    nbeats = 0;
    for (int r = 0; r <= cnt; r++) begin
      for (int b = 0; b < rb / 8; b++) begin
        exp_ext.push_back((ext + 8 * b) & 32'hFFFFFF);
        exp_loc.push_back((bank << 9) | (off >> 3));
        off = (off + 8) & 32'hFF8;
        nbeats++;
      end
      if (r < cnt) ext = ((ext + rb + skip) & 32'hFFFFFF) & ~32'h7;
    end
  endtask

  task automatic launch(input bit out, input logic [31:0] lv, input logic [31:0] ev,
                        input logic [31:0] lenv, output int nbeats);
    wr(2'd0, lv);
    wr(2'd1, ev);
    if (out) for (int i = 0; i < 1024; i++) lmem[i] = gdat(i);
    plan(lv, ev, lenv, nbeats);
    exp_out = out;
    fire_cnt = 0;
    mism = 0;
    wr(out ? 2'd3 : 2'd2, lenv);
  endtask

  task automatic finish_chk(input logic [31:0] lenv, input int nbeats, input string tag);
    logic [31:0] v;
    wait_idle();
    chk(mism == 0 && exp_ext.size() == 0, {tag, " R5 R6 R7 word sequence"}, mm_got, mm_exp);
    chk(fire_cnt == nbeats, {tag, " R3 R4 word count"}, fire_cnt, nbeats);
    rd(exp_out ? 2'd3 : 2'd2, v);
    chk(v == ((lenv & 32'hFFF00000) | 32'hFF8), {tag, " R8 finished length"}, v,
        (lenv & 32'hFFF00000) | 32'hFF8);
  endtask

  initial begin
    logic [31:0] v;
    int nb;
    int lens [6] = '{0, 7, 8, 15, 20, 33};
    int skips [4] = '{0, 3, 8, 13};
    int k;
    for (int i = 0; i < 1024; i++) lmem[i] = gdat(i);
    repeat (3) @(negedge clk);
    // R11 during reset
    chk(!busy && !ext_valid, "R11 outputs in reset", {busy, ext_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk(v == 0, "R11 register reset value", v, 0);
    end

    // R1 / R2 masking
    wr(2'd0, 32'hFFFFFFFF); rd(2'd0, v);
    chk(v == 32'h1FF8, "R1 local mask all ones", v, 32'h1FF8);
    wr(2'd0, 32'h0000_0A5F); rd(2'd0, v);
    chk(v == 32'h0A58, "R1 local mask pattern", v, 32'h0A58);
    wr(2'd1, 32'hFFFFFFFF); rd(2'd1, v);
    chk(v == 32'hFFFFF8, "R2 external mask all ones", v, 32'hFFFFF8);
    wr(2'd1, 32'h1234_5677); rd(2'd1, v);
    chk(v == 32'h345670, "R2 external mask pattern", v, 32'h345670);

    // R7 both length selectors read the same word
    launch(1'b0, 32'h0, 32'h80, 32'h0000_0000, nb);
    finish_chk(32'h0, nb, "first inbound");
    rd(2'd2, v);
    begin
      logic [31:0] v3;
      rd(2'd3, v3);
      chk(v == v3, "R7 selector 2 and 3 read alike", v3, v);
    end

    // sweep over rows, counts, skips, directions and ready patterns
    k = 0;
    for (int li = 0; li < 6; li++)
      for (int c = 0; c < 3; c++)
        for (int si = 0; si < 4; si++)
          for (int d = 0; d < 2; d++) begin
            logic [31:0] lenv;
            lenv = (32'(skips[si]) << 20) | (32'(c) << 12) | 32'(lens[li]);
            rdy_mode = k % 4;
            rdy_force = 1'b1;
            launch(d[0], (32'(k) * 32'h88) & 32'h1FF8, 32'h100 + 32'(k) * 32'h40, lenv, nb);
            finish_chk(lenv, nb, "sweep");
            k++;
          end

    // R6 local wrap in bank 1, R5 external wrap at the top of the space
    rdy_mode = 1;
    launch(1'b0, 32'h1FE8, 32'hFFFFF0, (32'd5 << 20) | (32'd1 << 12) | 32'd31, nb);
    finish_chk((32'd5 << 20) | (32'd1 << 12) | 32'd31, nb, "wrap inbound");
    launch(1'b1, 32'h0FF0, 32'hFFFFE8, (32'd9 << 20) | (32'd2 << 12) | 32'd16, nb);
    finish_chk((32'd9 << 20) | (32'd2 << 12) | 32'd16, nb, "wrap outbound");

    // R9 length write while busy is ignored
    rdy_mode = 1;
    launch(1'b1, 32'h200, 32'h4000, (32'd2 << 20) | (32'd1 << 12) | 32'd63, nb);
    wr(2'd2, 32'h7FF0_3005);
    rd(2'd3, v);
    chk(v == ((32'd2 << 20) | (32'd1 << 12) | 32'd63), "R9 busy write ignored", v,
        (32'd2 << 20) | (32'd1 << 12) | 32'd63);
    chk(busy, "R9 busy held during transfer", busy, 1);
    finish_chk((32'd2 << 20) | (32'd1 << 12) | 32'd63, nb, "busy write");

    // R9 length write in the cycle of the final accepted word
    rdy_mode = 2;
    rdy_force = 1'b0;
    launch(1'b0, 32'h40, 32'h9000, 32'h1230_0000, nb);
    chk(busy, "R10 R9 busy while stalled", busy, 1);
    repeat (2) @(negedge clk);
    rdy_force = 1'b1;
    reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0560_0038;
    @(negedge clk);
    reg_wr = 1'b0;
    #2;
    chk(!busy, "R9 idle after final word", busy, 0);
    rd(2'd2, v);
    chk(v == 32'h1230_0FF8, "R9 R8 collision keeps finished value", v, 32'h1230_0FF8);
    repeat (4) @(negedge clk);
    #2;
    chk(fire_cnt == 1 && !busy, "R9 no relaunch after collision", fire_cnt, 1);
    rdy_mode = 0;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule